// File: doc/BRIEF.md
# Three-level nested interrupt controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. It takes eleven ordinary request lines and one power-supply-management request. It keeps the enable and priority settings in four byte-wide registers, which software reaches through a plain address/data port. It presents at most one request at a time to the core, together with a vector index. The core signals entry into a service routine with an acknowledge pulse and leaves it with a return pulse. From these two pulses the controller tracks which priority tiers are currently being served.

There are three tiers. Each ordinary source sits in the low or the high tier, as chosen by its priority bit. The power-supply-management request is alone in a third tier above both, and it can break into any routine except its own. A tier that is in service blocks every request of the same tier or below. Between tiers, the higher one wins. Within a tier, the lowest source index wins. Two of the sources (external 0 and external 1) are edge-captured; the rest are level-sensitive.

Top module: `irq_nest3_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `in_service` is 000 and `int_req` is low.
- R2: Register address 0 holds the enables, from bit 7 down: global enable, reserved (reads 0), source 5 (timer 2), source 4 (serial port), source 3 (timer 1), source 2 (external 1), source 1 (timer 0), source 0 (external 0). Address 1 holds the priority bits of sources 5..0 in bits 5..0. Address 2 holds the enables of sources 6..10 in bits 0..4. Address 3 holds the priority bits of sources 6..10 in bits 0..4. Every other bit reads 0. A priority bit of 1 selects the high tier.
- R3: When the global enable is 0, no ordinary source is presented. The power-supply-management request is still presented.
- R4: A source is presented only if it is pending and enabled, and its tier (power > high > low) is strictly above the highest tier in service.
- R5: Among eligible sources, a higher tier wins over a lower one. Within a tier, the lowest source index wins.
- R6: The power-supply-management request uses vector 12. It is presented whenever its tier is not in service, so it preempts both the low and the high tier.
- R7: `int_req` and `int_vec` are registered: they reflect the inputs and state of the previous cycle. `int_req` is low in the cycle after any `int_ack` pulse.
- R8: An `int_ack` while `int_req` is high sets the `in_service` bit of the presented tier. An `int_ack` while `int_req` is low changes nothing.
- R9: An `int_reti` pulse clears the highest set `in_service` bit. With no bit set, it has no effect.
- R10: Sources 0 and 2 capture a rising edge into a pending latch. The latch is cleared when that source's vector is acknowledged. All other sources are pending while their input is high.
- R11: `in_service` bit 2 is the power tier, bit 1 the high tier and bit 0 the low tier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 11 | Ordinary request lines, index = vector |
| psm_req | input | 1 | Power-supply-management request (level) |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| int_ack | input | 1 | Core entered the presented routine |
| int_reti | input | 1 | Core returned from a routine |
| int_req | output | 1 | Interrupt presented to the core |
| int_vec | output | 4 | Vector index of the presented interrupt |
| in_service | output | 3 | Tiers currently in service |

## Verification
The bound checker checks several rules on every cycle. A request is withdrawn after an acknowledge. The power request is presented with vector 12 whenever its tier is free. Nothing is presented while the power tier is in service. The global enable masks the ordinary sources. A return clears the power tier. An acknowledge without a request leaves the tier flags alone. Which ordinary source wins and when is checked only by the bench, because that depends on register contents and on the order of events. The bench's scenarios cover polling order across tiers, preemption of a low routine by a high request, nesting and unwinding by returns, and edge capture and clearing.

// File: rtl/irq_nest3_ctrl.sv
module irq_nest3_ctrl #(
  parameter int NUSR = 11,
  parameter int VW = 4,
  parameter logic [15:0] EDGE_MASK = 16'h0005,
  parameter logic [VW-1:0] PSM_VEC = 4'd12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NUSR-1:0] irq_src,
  input  logic            psm_req,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            int_ack,
  input  logic            int_reti,
  output logic            int_req,
  output logic [VW-1:0]   int_vec,
  output logic [2:0]      in_service
);
  localparam int NHI = NUSR - 6;
  localparam logic [NUSR-1:0] EMASK = EDGE_MASK[NUSR-1:0];

  logic            gie;
  logic [NUSR-1:0] en, pri, src_d, lat;
  logic [NUSR-1:0] pend, elig, hi_set, lo_set, clr;
  logic [2:0]      isv, isv_top, isv_n;
  logic            req_q, ack_ok;
  logic [VW-1:0]   vec_q, cand_vec;
  logic [1:0]      lvl_q, cand_lvl;
  logic            cand_ok, psm_ok, hi_ok, lo_ok;
  logic            unused_wbits;

  function automatic logic [VW-1:0] first_idx(input logic [NUSR-1:0] v);
    first_idx = '0;
    for (int i = NUSR - 1; i >= 0; i--)
      if (v[i]) first_idx = VW'(i);
  endfunction

  assign unused_wbits = ^reg_wdata;

  assign pend   = (lat & EMASK) | (irq_src & ~EMASK);
  assign elig   = pend & en & {NUSR{gie}};
  assign hi_set = elig & pri;
  assign lo_set = elig & ~pri;

  assign psm_ok = psm_req & ~isv[2];
  assign hi_ok  = (|hi_set) & ~(|isv[2:1]);
  assign lo_ok  = (|lo_set) & ~(|isv);

  always_comb begin
    cand_ok  = 1'b1;
    cand_vec = '0;
    cand_lvl = 2'd0;
    if (psm_ok) begin
      cand_vec = PSM_VEC;
      cand_lvl = 2'd2;
    end else if (hi_ok) begin
      cand_vec = first_idx(hi_set);
      cand_lvl = 2'd1;
    end else if (lo_ok) begin
      cand_vec = first_idx(lo_set);
    end else begin
      cand_ok = 1'b0;
    end
  end

  assign ack_ok  = int_ack & req_q;
  assign clr     = ack_ok ? (NUSR'(1) << vec_q) : '0;
  assign isv_top = isv[2] ? 3'b100 : isv[1] ? 3'b010 : isv[0] ? 3'b001 : 3'b000;
  assign isv_n   = (isv & ~(int_reti ? isv_top : 3'b000))
                 | (ack_ok ? (3'b001 << lvl_q) : 3'b000);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata = {gie, 1'b0, en[5:0]};
      2'd1:    reg_rdata = {2'b00, pri[5:0]};
      2'd2:    reg_rdata[NHI-1:0] = en[NUSR-1:6];
      default: reg_rdata[NHI-1:0] = pri[NUSR-1:6];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      en  <= '0;
      pri <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          gie     <= reg_wdata[7];
          en[5:0] <= reg_wdata[5:0];
        end
        2'd1:    pri[5:0]      <= reg_wdata[5:0];
        2'd2:    en[NUSR-1:6]  <= reg_wdata[NHI-1:0];
        default: pri[NUSR-1:6] <= reg_wdata[NHI-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= '0;
      lat   <= '0;
      isv   <= '0;
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= 2'd0;
    end else begin
      src_d <= irq_src;
      lat   <= ((lat & ~clr) | (irq_src & ~src_d)) & EMASK;
      isv   <= isv_n;
      req_q <= cand_ok & ~int_ack;
      vec_q <= cand_vec;
      lvl_q <= cand_lvl;
    end
  end

  assign int_req    = req_q;
  assign int_vec    = vec_q;
  assign in_service = isv;
endmodule

// File: rtl/irq_nest3_ctrl_chk.sv
module irq_nest3_ctrl_chk #(
  parameter int NUSR = 11,
  parameter int VW = 4,
  parameter logic [VW-1:0] PSM_VEC = 4'd12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psm_req,
  input logic          int_ack,
  input logic          int_reti,
  input logic          int_req,
  input logic [VW-1:0] int_vec,
  input logic [2:0]    in_service,
  input logic          gie
);
  p_ack_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_req);

  p_psm_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (psm_req && !in_service[2] && !int_ack) |=> (int_req && int_vec == PSM_VEC));

  p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int'(int_vec) < NUSR || int_vec == PSM_VEC));

  p_top_tier_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_service[2] |-> !int_req);

  p_gie_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !psm_req) |=> !int_req);

  p_reti_clears_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_reti && !(int_ack && int_req) && in_service[2]) |=> !in_service[2]);

  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !int_reti) |=> $stable(in_service));
endmodule

bind irq_nest3_ctrl irq_nest3_ctrl_chk #(.NUSR(NUSR), .VW(VW), .PSM_VEC(PSM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .psm_req(psm_req), .int_ack(int_ack),
  .int_reti(int_reti), .int_req(int_req), .int_vec(int_vec),
  .in_service(in_service), .gie(gie)
);

// File: tb/irq_nest3_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest3_ctrl_tb;
  localparam int NUSR = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NUSR-1:0] irq_src = '0;
  logic            psm_req = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic            int_ack = 1'b0;
  logic            int_reti = 1'b0;
  wire  [7:0]      reg_rdata;
  wire             int_req;
  wire  [3:0]      int_vec;
  wire  [2:0]      in_service;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  irq_nest3_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .psm_req(psm_req),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_ack(int_ack), .int_reti(int_reti),
    .int_req(int_req), .int_vec(int_vec), .in_service(in_service)
  );

  // reference model state
  bit            m_gie;
  bit [NUSR-1:0] m_en, m_pri, m_prev, m_lat;
  bit [2:0]      m_isv;
  bit            m_req;
  int            m_vec, m_lvl;

  function automatic bit is_edge(int i);
    return (i == 0) || (i == 2);
  endfunction

  always @(posedge clk) begin : model
    int cv, cl;
    bit cok, ackd;
    bit [NUSR-1:0] p;
    if (!rst_n) begin
      m_gie = 0; m_en = '0; m_pri = '0; m_prev = '0; m_lat = '0;
      m_isv = '0; m_req = 0; m_vec = 0; m_lvl = 0;
    end else begin
      cok = 0; cv = 0; cl = 0;
      for (int i = 0; i < NUSR; i++) p[i] = is_edge(i) ? m_lat[i] : irq_src[i];
      if (psm_req && !m_isv[2]) begin
        cok = 1; cv = 12; cl = 2;
      end else begin
        if (!m_isv[2] && !m_isv[1])
          for (int i = NUSR - 1; i >= 0; i--)
            if (p[i] && m_en[i] && m_gie && m_pri[i]) begin cok = 1; cv = i; cl = 1; end
        if (!cok && m_isv == 3'b000)
          for (int i = NUSR - 1; i >= 0; i--)
            if (p[i] && m_en[i] && m_gie && !m_pri[i]) begin cok = 1; cv = i; cl = 0; end
      end
      ackd = int_ack && m_req;
      if (int_reti) begin
        if (m_isv[2]) m_isv[2] = 0;
        else if (m_isv[1]) m_isv[1] = 0;
        else if (m_isv[0]) m_isv[0] = 0;
      end
      if (ackd) m_isv[m_lvl] = 1;
      for (int i = 0; i < NUSR; i++)
        if (is_edge(i)) begin
          if (ackd && m_vec == i) m_lat[i] = 0;
          if (irq_src[i] && !m_prev[i]) m_lat[i] = 1;
        end
      if (reg_wr)
        case (reg_addr)
          2'd0: begin m_gie = reg_wdata[7]; m_en[5:0] = reg_wdata[5:0]; end
          2'd1: m_pri[5:0] = reg_wdata[5:0];
          2'd2: m_en[10:6] = reg_wdata[4:0];
          default: m_pri[10:6] = reg_wdata[4:0];
        endcase
      m_prev = irq_src;
      m_req = cok && !int_ack;
      m_vec = cv;
      m_lvl = cl;
    end
  end

  function automatic logic [7:0] exp_rd();
    case (reg_addr)
      2'd0: return {m_gie, 1'b0, m_en[5:0]};
      2'd1: return {2'b00, m_pri[5:0]};
      2'd2: return {3'b000, m_en[10:6]};
      default: return {3'b000, m_pri[10:6]};
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("int_req", 32'(int_req), 32'(m_req));
    if (m_req) chk("int_vec", 32'(int_vec), 32'(m_vec));
    chk("in_service", 32'(in_service), 32'(m_isv));
    chk("reg_rdata", 32'(reg_rdata), 32'(exp_rd()));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic ack();
    int_ack = 1'b1; tick(1); int_ack = 1'b0;
  endtask

  task automatic reti();
    int_reti = 1'b1; tick(1); int_reti = 1'b0;
  endtask

  task automatic read_all();
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(1); end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R1"; tick(3); rst_n = 1'b1; tick(2); read_all();
    tag = "R2";
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); read_all();
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00); read_all();
    tag = "R3";
    wr(2, 8'h1F); wr(0, 8'h3F); irq_src = '1; tick(4);
    tag = "R6"; psm_req = 1'b1; tick(2); ack(); tick(3); psm_req = 1'b0; reti(); tick(2);
    tag = "R5"; wr(0, 8'hBF); tick(2); wr(1, 8'h20); tick(2);
    tag = "R8"; ack(); tick(2);
    tag = "R4"; tick(3);
    tag = "R6"; psm_req = 1'b1; tick(2); ack(); psm_req = 1'b0; tick(2);
    tag = "R9"; reti(); tick(3); reti(); tick(2);
    tag = "R5"; irq_src[5] = 1'b0; tick(2);
    tag = "R10"; ack(); tick(2);
    tag = "R4"; wr(1, 8'h08); tick(2); ack(); tick(2); reti(); tick(1); reti(); tick(2);
    tag = "R9"; tick(1); reti(); reti(); tick(2);
    tag = "R8"; wr(0, 8'h00); tick(2); ack(); tick(2);
    tag = "R10"; irq_src = '0; wr(0, 8'hBF); wr(1, 8'h00); wr(3, 8'h00); tick(2);
    irq_src[2] = 1'b1; tick(1); irq_src[2] = 1'b0; tick(3); ack(); tick(2); reti(); tick(2);
    irq_src[0] = 1'b1; tick(1); irq_src[2] = 1'b1; tick(2); ack(); tick(2); reti(); tick(2); ack(); tick(1); reti(); tick(2);
    tag = "R7"; irq_src[7] = 1'b1; tick(1); ack(); tick(1); reti(); tick(2); irq_src[7] = 1'b0; tick(2);
    tag = "R5"; wr(3, 8'h08); irq_src[1] = 1'b1; irq_src[9] = 1'b1; psm_req = 1'b1; tick(2);
    ack(); psm_req = 1'b0; tick(2); ack(); tick(2); reti(); reti(); tick(2); ack(); tick(2); reti(); tick(2);
    tag = "R11"; irq_src = '0; tick(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule